// File: doc/BRIEF.md
# TDM Audio Link Frame Transmitter

This block is the controller-side sender of a bidirectional time-division audio link. It runs in the bit-clock domain and drives two wires: a frame sync and a serial data line. Every frame is 256 bit times long. It opens with a 16-bit tag slot and then carries twelve 20-bit slots. The tag tells the far end whether the frame as a whole holds meaning, which of the twelve slots carry data, and which codec is addressed. Slot 1 holds a register command (a read/write flag and a register index). Slot 2 holds the write data for that command. Slots 3 to 12 hold 20-bit audio samples.

Upstream logic presents the tag fields, the command and the payload as level inputs. The transmitter samples all of them in one cycle, on the clock edge that drives the first tag bit. It copies them into a shadow shift register, so a change made partway through a frame can never split a frame. A one-cycle `frame_start` strobe marks that edge. Upstream logic then has the whole frame to prepare the next set of values. The block changes its outputs on the rising clock edge, so the receiver can sample them on the falling edge.

At the nominal 12.288 MHz bit clock the block sends 48,000 frames per second.

Top module: `tdm_frame_tx`

## Requirements
- R1: A frame is 256 bit times. `frame_start` is high for exactly one cycle per frame, in the cycle where tag bit F0 is on `sdo`. Consecutive strobes are 256 cycles apart.
- R2: `sync` is high for 16 consecutive bit times. It rises in the cycle that carries F255 of the previous frame and stays high through F14. It is low for the other 240 bit times.
- R3: Tag bits are sent in this order: F0 is `frame_valid`; F1 to F12 are `slot_valid[0]` to `slot_valid[11]`, where `slot_valid[k-1]` flags slot k; F13 is always 0; F14 is `codec_id[1]`; F15 is `codec_id[0]`.
- R4: Slot 1 occupies F16 to F35. F16 is `cmd_rw`. F17 to F23 are `cmd_index[6]` down to `cmd_index[0]`. F24 to F35 are 0.
- R5: Slot 2 occupies F36 to F55. F36 to F51 are `cmd_wdata[15]` down to `cmd_wdata[0]`. F52 to F55 are 0.
- R6: Slot s, for s from 3 to 12, occupies 20 bits starting at F(16+20*(s-1)). It carries `audio_data[(s-3)*20 +: 20]`, MSB first.
- R7: When `slot_valid[s-1]` is 0, all 20 bits of slot s are sent as 0, whatever the slot's input value is.
- R8: Inputs are sampled only on the edge that drives F0. Changing any input during the rest of the frame has no effect on the bits sent.
- R9: While `rst_n` is low, `sync`, `sdo` and `frame_start` are all low.
- R10: After `rst_n` is released, `sync` first goes high on rising edge START_DELAY+1, in a cycle where `sdo` is 0. The first `frame_start` and F0 follow on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | Whole-frame valid flag, sent as F0 |
| slot_valid | input | 12 | Bit k-1 flags slot k as carrying data |
| codec_id | input | 2 | Target codec number, sent as F14..F15 |
| cmd_rw | input | 1 | Command direction flag, 1 = read |
| cmd_index | input | 7 | Register index of the command |
| cmd_wdata | input | 16 | Register write data |
| audio_data | input | 200 | Ten 20-bit samples; slot 3 in the lowest 20 bits |
| sync | output | 1 | Frame sync |
| sdo | output | 1 | Serial data, MSB of each slot first |
| frame_start | output | 1 | One-cycle strobe while F0 is on `sdo` |

## Verification
The checker counts bit positions from `frame_start`. It assumes `slot_valid` is steady on the edge that drives F0, and it uses the value latched there to decide which slots must be silent. It also assumes the reset is the only thing that can break the frame rhythm, so the period and sync-width counters are only checked under a steady reset-free run. The stimulus holds to this. It changes inputs only on falling edges, and it loads each new vector well before the last bit of the current frame. Its one deliberate mid-frame input change falls at bit 100, far from any frame boundary.

// File: rtl/tdm_link_pkg.sv
package tdm_link_pkg;

   typedef enum logic {
      SEQ_WAIT = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   // bit position of frame bit Fn inside a frame vector, MSB = F0
   function automatic int frame_pos(input int frame_w, input int fbit);
      return frame_w - 1 - fbit;
   endfunction

endpackage

// File: rtl/tdm_frame_builder.sv
module tdm_frame_builder
   import tdm_link_pkg::*;
#(
   parameter int TAG_W     = 16,
   parameter int SLOT_W    = 20,
   parameter int NUM_SLOTS = 12,
   parameter int ID_W      = 2,
   parameter int IDX_W     = 7,
   parameter int WDATA_W   = 16,
   localparam int NUM_AUD  = NUM_SLOTS - 2,
   localparam int FRAME_W  = TAG_W + NUM_SLOTS * SLOT_W
) (
   input  logic                      frame_valid,
   input  logic [NUM_SLOTS-1:0]      slot_valid,
   input  logic [ID_W-1:0]           codec_id,
   input  logic                      cmd_rw,
   input  logic [IDX_W-1:0]          cmd_index,
   input  logic [WDATA_W-1:0]        cmd_wdata,
   input  logic [NUM_AUD*SLOT_W-1:0] audio_data,
   output logic [FRAME_W-1:0]        frame_o
);

   localparam int GAP_BIT = TAG_W - 1 - ID_W;   // reserved tag bit position (as frame bit index)

   logic [TAG_W-1:0] tag_word;

   always_comb begin
      tag_word = '0;
      tag_word[TAG_W-1] = frame_valid;
      for (int k = 0; k < NUM_SLOTS; k++) begin
         tag_word[TAG_W-2-k] = slot_valid[k];
      end
      tag_word[TAG_W-1-GAP_BIT] = 1'b0;
      tag_word[ID_W-1:0] = codec_id;
   end

   assign frame_o[FRAME_W-1 -: TAG_W] = tag_word;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic [SLOT_W-1:0] raw;
      if (s == 0) begin : g_cmd
         always_comb begin
            raw = '0;
            raw[SLOT_W-1] = cmd_rw;
            raw[SLOT_W-2 -: IDX_W] = cmd_index;
         end
      end else if (s == 1) begin : g_wdata
         always_comb begin
            raw = '0;
            raw[SLOT_W-1 -: WDATA_W] = cmd_wdata;
         end
      end else begin : g_audio
         assign raw = audio_data[(s-2)*SLOT_W +: SLOT_W];
      end
      assign frame_o[FRAME_W-1-TAG_W-s*SLOT_W -: SLOT_W] = slot_valid[s] ? raw : '0;
   end

endmodule

// File: rtl/tdm_link_sequencer.sv
module tdm_link_sequencer
   import tdm_link_pkg::*;
#(
   parameter int FRAME_W     = 256,
   parameter int SYNC_LEN    = 16,
   parameter int START_DELAY = 8,
   localparam int CNT_W      = $clog2(FRAME_W),
   localparam int DLY_W      = $clog2(START_DELAY + 2)
) (
   input  logic clk,
   input  logic rst_n,
   output logic load_o,
   output logic sync_o,
   output logic start_o
);

   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
   localparam logic [DLY_W-1:0] DLY_INIT = DLY_W'(START_DELAY);

   seq_state_e       state_q;
   logic [DLY_W-1:0] wait_q;
   logic [CNT_W-1:0] bit_q;
   logic [CNT_W-1:0] bit_nxt;

   assign bit_nxt = (bit_q == LAST_BIT) ? '0 : bit_q + 1'b1;
   assign load_o  = (state_q == SEQ_RUN) && (bit_q == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_WAIT;
         wait_q  <= DLY_INIT;
         bit_q   <= LAST_BIT;
         sync_o  <= 1'b0;
         start_o <= 1'b0;
      end else begin
         case (state_q)
            SEQ_WAIT: begin
               start_o <= 1'b0;
               if (wait_q == '0) begin
                  state_q <= SEQ_RUN;
                  bit_q   <= LAST_BIT;
                  sync_o  <= 1'b1;
               end else begin
                  wait_q  <= wait_q - 1'b1;
               end
            end
            default: begin
               bit_q   <= bit_nxt;
               sync_o  <= (bit_nxt == LAST_BIT) || (bit_nxt < CNT_W'(SYNC_LEN - 1));
               start_o <= (bit_nxt == '0);
            end
         endcase
      end
   end

endmodule

// File: rtl/tdm_frame_shifter.sv
module tdm_frame_shifter #(
   parameter int FRAME_W = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [FRAME_W-1:0] frame_i,
   output logic               sdo_o
);

   logic [FRAME_W-1:0] shadow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
      end else if (load_i) begin
         shadow_q <= frame_i;
      end else begin
         shadow_q <= {shadow_q[FRAME_W-2:0], 1'b0};
      end
   end

   assign sdo_o = shadow_q[FRAME_W-1];

endmodule

// File: rtl/tdm_frame_tx.sv
module tdm_frame_tx
   import tdm_link_pkg::*;
#(
   parameter int TAG_W       = 16,
   parameter int SLOT_W      = 20,
   parameter int NUM_SLOTS   = 12,
   parameter int ID_W        = 2,
   parameter int IDX_W       = 7,
   parameter int WDATA_W     = 16,
   parameter int SYNC_LEN    = 16,
   parameter int START_DELAY = 8,
   localparam int NUM_AUD    = NUM_SLOTS - 2,
   localparam int FRAME_W    = TAG_W + NUM_SLOTS * SLOT_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      frame_valid,
   input  logic [NUM_SLOTS-1:0]      slot_valid,
   input  logic [ID_W-1:0]           codec_id,
   input  logic                      cmd_rw,
   input  logic [IDX_W-1:0]          cmd_index,
   input  logic [WDATA_W-1:0]        cmd_wdata,
   input  logic [NUM_AUD*SLOT_W-1:0] audio_data,
   output logic                      sync,
   output logic                      sdo,
   output logic                      frame_start
);

   if (TAG_W != 2 + NUM_SLOTS + ID_W) begin : g_chk_tag
      $error("tag width must hold frame flag, slot flags, gap bit and codec id");
   end
   if (NUM_SLOTS < 3) begin : g_chk_slots
      $error("at least one payload slot is required");
   end
   if (SLOT_W < 1 + IDX_W || SLOT_W < WDATA_W) begin : g_chk_slot_w
      $error("slot width too small for command fields");
   end
   if (SYNC_LEN < 2 || SYNC_LEN >= FRAME_W) begin : g_chk_sync
      $error("sync length out of range");
   end

   logic [FRAME_W-1:0] frame_w;
   logic               load_w;

   tdm_frame_builder #(
      .TAG_W     (TAG_W),
      .SLOT_W    (SLOT_W),
      .NUM_SLOTS (NUM_SLOTS),
      .ID_W      (ID_W),
      .IDX_W     (IDX_W),
      .WDATA_W   (WDATA_W)
   ) u_build (
      .frame_valid (frame_valid),
      .slot_valid  (slot_valid),
      .codec_id    (codec_id),
      .cmd_rw      (cmd_rw),
      .cmd_index   (cmd_index),
      .cmd_wdata   (cmd_wdata),
      .audio_data  (audio_data),
      .frame_o     (frame_w)
   );

   tdm_link_sequencer #(
      .FRAME_W     (FRAME_W),
      .SYNC_LEN    (SYNC_LEN),
      .START_DELAY (START_DELAY)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_o  (load_w),
      .sync_o  (sync),
      .start_o (frame_start)
   );

   tdm_frame_shifter #(
      .FRAME_W (FRAME_W)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_w),
      .frame_i (frame_w),
      .sdo_o   (sdo)
   );

endmodule

// File: rtl/tdm_frame_tx_sva.sv
module tdm_frame_tx_sva #(
   parameter int FRAME_W   = 256,
   parameter int TAG_W     = 16,
   parameter int SLOT_W    = 20,
   parameter int NUM_SLOTS = 12,
   parameter int ID_W      = 2,
   parameter int SYNC_LEN  = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 sync,
   input logic                 sdo,
   input logic                 frame_start,
   input logic [NUM_SLOTS-1:0] slot_valid
);

   localparam int CW = $clog2(FRAME_W) + 2;

   logic [CW-1:0]        gap_q, run_q, pos_q, cur;
   logic                 seen_q, rst_prev_q, dead_bit;
   logic [NUM_SLOTS-1:0] prev_v_q, cap_v_q;

   always_ff @(posedge clk) rst_prev_q <= !rst_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q    <= '0;
         run_q    <= '0;
         pos_q    <= '0;
         seen_q   <= 1'b0;
         prev_v_q <= '0;
         cap_v_q  <= '0;
      end else begin
         run_q    <= sync ? run_q + 1'b1 : '0;
         gap_q    <= frame_start ? CW'(1) : ((&gap_q) ? gap_q : gap_q + 1'b1);
         pos_q    <= frame_start ? CW'(1) : ((&pos_q) ? pos_q : pos_q + 1'b1);
         prev_v_q <= slot_valid;
         if (frame_start) begin
            seen_q  <= 1'b1;
            cap_v_q <= prev_v_q;
         end
      end
   end

   always_comb begin
      cur = frame_start ? '0 : pos_q;
      dead_bit = 1'b0;
      if (seen_q && int'(cur) >= TAG_W && int'(cur) < FRAME_W) begin
         dead_bit = !cap_v_q[(int'(cur) - TAG_W) / SLOT_W];
      end
   end

   AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && frame_start) |-> (gap_q == CW'(FRAME_W)));   // R1

   AST_SYNC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync && run_q != '0) |-> (run_q == CW'(SYNC_LEN)));   // R2

   AST_START_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (sync && $past(sync)));   // R2

   AST_TAG_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && cur == CW'(TAG_W - 1 - ID_W)) |-> !sdo);   // R3

   AST_DEAD_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      dead_bit |-> !sdo);   // R7

   AST_QUIET_IN_RESET: assert property (@(posedge clk)
      (!rst_n && rst_prev_q) |-> (!sync && !sdo && !frame_start));   // R9

endmodule

bind tdm_frame_tx tdm_frame_tx_sva #(
   .FRAME_W   (FRAME_W),
   .TAG_W     (TAG_W),
   .SLOT_W    (SLOT_W),
   .NUM_SLOTS (NUM_SLOTS),
   .ID_W      (ID_W),
   .SYNC_LEN  (SYNC_LEN)
) u_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .sync        (sync),
   .sdo         (sdo),
   .frame_start (frame_start),
   .slot_valid  (slot_valid)
);

// File: tb/sim_tdm_frame_tx.sv
module sim_tdm_frame_tx;

   localparam int DLY  = 8;
   localparam int FW   = 256;
   localparam int VW   = 59;
   localparam int NVEC = 5;

   // {frame_valid, slot_valid[11:0], codec_id[1:0], rw, index[6:0], wdata[15:0], audio seed[19:0]}
   localparam logic [VW-1:0] VEC [NVEC] = '{
      {1'b1, 12'hFFF, 2'b10, 1'b1, 7'h55, 16'hBEEF, 20'hA5A5A},
      {1'b1, 12'h000, 2'b01, 1'b0, 7'h2A, 16'h1234, 20'hFFFFF},
      {1'b0, 12'h555, 2'b11, 1'b0, 7'h7F, 16'hFFFF, 20'h12345},
      {1'b1, 12'hAAA, 2'b00, 1'b1, 7'h00, 16'h8001, 20'h80001},
      {1'b1, 12'h003, 2'b01, 1'b0, 7'h40, 16'h0F0F, 20'h7FFFF}
   };

   logic         clk = 1'b0;
   logic         rst_n;
   logic         frame_valid;
   logic [11:0]  slot_valid;
   logic [1:0]   codec_id;
   logic         cmd_rw;
   logic [6:0]   cmd_index;
   logic [15:0]  cmd_wdata;
   logic [199:0] audio_data;
   logic         sync, sdo, frame_start;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tdm_frame_tx #(.START_DELAY(DLY)) u0 (
      .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .slot_valid(slot_valid),
      .codec_id(codec_id), .cmd_rw(cmd_rw), .cmd_index(cmd_index), .cmd_wdata(cmd_wdata),
      .audio_data(audio_data), .sync(sync), .sdo(sdo), .frame_start(frame_start)
   );

   task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [199:0] audio_of(input logic [19:0] seed);
      logic [199:0] a;
      for (int i = 0; i < 10; i++) a[i*20 +: 20] = seed + 20'(i * 32'h13579);
      return a;
   endfunction

   task automatic apply(input logic [VW-1:0] v);
      {frame_valid, slot_valid, codec_id, cmd_rw, cmd_index, cmd_wdata} = v[VW-1:20];
      audio_data = audio_of(v[19:0]);
   endtask

   // expected frame, vector bit [255-n] is frame bit Fn
   function automatic logic [255:0] model(input logic [VW-1:0] v);
      logic [255:0] f;
      logic [11:0]  sv;
      logic [199:0] au;
      logic [19:0]  val;
      f  = '0;
      sv = v[57:46];
      au = audio_of(v[19:0]);
      f[255] = v[58];
      for (int n = 1; n <= 12; n++) f[255-n] = sv[n-1];
      f[255-14] = v[45];
      f[255-15] = v[44];
      for (int s = 1; s <= 12; s++) begin
         if (s == 1)      val = {v[43], v[42:36], 12'h000};
         else if (s == 2) val = {v[35:20], 4'h0};
         else             val = au[(s-3)*20 +: 20];
         if (!sv[s-1]) val = '0;
         for (int j = 0; j < 20; j++) f[255 - (16 + 20*(s-1) + j)] = val[19-j];
      end
      return f;
   endfunction

   // called at the falling edge inside the cycle carrying F0
   task automatic collect(input int vi);
      logic [255:0] rx, ex;
      int sync_bad, fs_bad;
      rx = '0; sync_bad = 0; fs_bad = 0;
      ex = model(VEC[vi]);
      for (int n = 0; n < FW; n++) begin
         if (n > 0) @(negedge clk);
         rx[255-n] = sdo;
         if (sync !== ((n <= 14) || (n == 255))) sync_bad++;
         if (frame_start !== (n == 0)) fs_bad++;
         if (n == 100) apply({VW{1'b1}});          // mid-frame change, R8
         if (n == 200 && vi + 1 < NVEC) apply(VEC[vi+1]);
      end
      check(fs_bad == 0, "R1 frame_start once per 256", 256'(fs_bad), 256'(0));
      check(sync_bad == 0, "R2 sync window", 256'(sync_bad), 256'(0));
      check(rx[255:240] == ex[255:240], "R3 tag slot", 256'(rx[255:240]), 256'(ex[255:240]));
      check(rx[239:220] == ex[239:220], "R4 command slot", 256'(rx[239:220]), 256'(ex[239:220]));
      check(rx[219:200] == ex[219:200], "R5 write data slot", 256'(rx[219:200]), 256'(ex[219:200]));
      // R7 invalid slots zero, R8 mid-frame change ignored: covered by the full compare
      check(rx[199:0] == ex[199:0], "R6 R7 R8 audio slots", 256'(rx[199:0]), 256'(ex[199:0]));
   endtask

   initial begin
      rst_n = 1'b0;
      apply(VEC[0]);
      repeat (3) @(negedge clk);
      check(!sync && !sdo && !frame_start, "R9 quiet in reset",
            256'({sync, sdo, frame_start}), 256'(0));
      rst_n = 1'b1;
      for (int k = 1; k <= DLY + 1; k++) begin
         @(negedge clk);
         if (k <= DLY) begin
            if (sync !== 1'b0 || frame_start !== 1'b0) begin
               check(1'b0, "R10 sync early", 256'(k), 256'(DLY + 1));
            end
         end else begin
            check(sync === 1'b1 && sdo === 1'b0 && frame_start === 1'b0,
                  "R10 sync on edge START_DELAY+1", 256'({sync, sdo, frame_start}), 256'(3'b100));
         end
      end
      @(negedge clk);
      check(frame_start === 1'b1, "R10 first F0 next edge", 256'(frame_start), 256'(1));
      for (int v = 0; v < NVEC; v++) begin
         collect(v);
         @(negedge clk);
      end
      // mid-frame reset
      repeat (40) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(!sync && !sdo && !frame_start, "R9 quiet after mid-frame reset",
            256'({sync, sdo, frame_start}), 256'(0));
      repeat (2) @(negedge clk);
      check(!sync && !sdo && !frame_start, "R9 held in reset",
            256'({sync, sdo, frame_start}), 256'(0));
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule